// File: doc/BRIEF.md
# Serial Configuration Register Receiver

This block takes configuration writes from a three-wire serial master (a serial clock, a serial data line and an active-low select) and applies them to a small bank of 16-bit configuration registers. Every write is a 32-bit frame sent most significant bit first. The frame starts with a 12-bit synchronisation header. Next come a 4-bit register address and 16 bits of register data. Data is sampled on each rising edge of the serial clock. The registers are write-only, and their contents reach the rest of the chip only as parallel outputs.

The serial clock drives the shifting and the header search. A finished frame is held in a capture register and announced by flipping a toggle. A synchroniser brings the toggle into the system clock domain. There it produces a single-cycle write strobe with the address and data, and updates the register bank in the same cycle. The receiver takes frames only while the extended-control enable input is high. Frames may follow each other with select held low. Raising select abandons any partial frame and restarts the header search.

Top module: `cfg_serial_rx`

## Requirements
- R1: After system reset `wr_stb` is 0 and each register slot `a` of `cfg_regs` (bits `a*16+15` down to `a*16`) holds its default `{4'hA, a[3:0], 8'h5A}`.
- R2: A frame made of header 12'h001 (eleven 0s then a 1, first bit 0), then address bits 3 down to 0, then data bits 15 down to 0, all sampled on rising `ser_clk` while `ser_sel_n` is low, writes the data into the addressed implemented register. `wr_stb` then shows that address on `wr_addr` and that data on `wr_data`.
- R3: For a written frame, `wr_stb` is high for exactly one `clk` cycle. That cycle is the third rising `clk` edge after the 32nd rising `ser_clk` of the frame (two synchroniser stages).
- R4: A new frame may start on the 33rd serial clock with `ser_sel_n` held low. Every frame in such a back-to-back run is applied, in order.
- R5: If the header bits do not match, no register is written. The receiver shifts its search one bit at a time and locks onto the next 12 consecutive bits that equal the header.
- R6: Raising `ser_sel_n` before the 32nd bit drops the partial frame without a write. The next frame after select falls again is decoded from a fresh header.
- R7: While `ext_en` is 0, serial activity writes nothing and produces no strobe.
- R8: Only addresses 0-3 and 8-14 are implemented (mask 16'h7F0F). A frame to address 4, 5, 6, 7 or 15 produces no strobe and leaves every register unchanged.
- R9: A register changes only in a cycle where `wr_stb` is high for its address. All other registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| ext_en | input | 1 | Extended-control enable; when low, serial writes are ignored |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_sel_n | input | 1 | Active-low select; high resets the frame search |
| wr_stb | output | 1 | Single-cycle write strobe in the `clk` domain |
| wr_addr | output | 4 | Address of the last applied write |
| wr_data | output | 16 | Data of the last applied write |
| cfg_regs | output | 256 | Flattened register bank, slot `a` at bits `a*16 +: 16` |

## Verification
The completion of one frame and the start of the next can fall in the same serial clock. In a back-to-back run, the last data bit of one frame and the first header bit of the next are adjacent edges, with no idle time in between. The bench sends such runs with select held low, and bad-header and bit-slip streams in which the header search must restart on the edge right after a discard. A behavioural model built on bit queues predicts which `clk` cycle carries each strobe. Every cycle it compares the strobe, address, data and the whole register bank, so a lost, doubled or shifted write shows up in the cycle it happens.

// File: rtl/cfg_rx_pkg.sv
`timescale 1ns/1ps
package cfg_rx_pkg;
    localparam int HDR_W   = 12;
    localparam int ADR_W   = 4;
    localparam int DAT_W   = 16;
    localparam int BODY_W  = ADR_W + DAT_W;
    localparam int NREG    = 1 << ADR_W;
    localparam logic [HDR_W-1:0] HDR_PATTERN = 12'h001;

    typedef struct packed {
        logic [ADR_W-1:0] addr;
        logic [DAT_W-1:0] data;
    } cfg_wr_t;

    function automatic logic [DAT_W-1:0] cfg_default(input logic [ADR_W-1:0] a);
        return {4'hA, a, 8'h5A};
    endfunction
endpackage

// File: rtl/cfg_shift_rx.sv
`timescale 1ns/1ps
module cfg_shift_rx
    import cfg_rx_pkg::*;
(
    input  logic    sclk,
    input  logic    sdat,
    input  logic    clr,
    input  logic    rst_n,
    output cfg_wr_t cap,
    output logic    tog
);
    localparam int CNT_W = $clog2(BODY_W);

    typedef struct packed {
        logic              lock;
        logic [HDR_W-1:0]  win;
        logic [BODY_W-1:0] body;
        logic [CNT_W-1:0]  cnt;
    } frm_t;

    localparam frm_t FRM_RST = '{lock: 1'b0, win: '1, body: '0, cnt: '0};

    frm_t    frm_d, frm_q;
    cfg_wr_t cap_d, cap_q;
    logic    tog_d, tog_q;

    always_comb begin
        frm_d = frm_q;
        cap_d = cap_q;
        tog_d = tog_q;
        if (!frm_q.lock) begin
            frm_d.win = {frm_q.win[HDR_W-2:0], sdat};
            if ({frm_q.win[HDR_W-2:0], sdat} == HDR_PATTERN) begin
                frm_d.lock = 1'b1;
                frm_d.cnt  = '0;
            end
        end else begin
            frm_d.body = {frm_q.body[BODY_W-2:0], sdat};
            frm_d.cnt  = frm_q.cnt + 1'b1;
            if (frm_q.cnt == CNT_W'(BODY_W-1)) begin
                frm_d.lock = 1'b0;
                frm_d.win  = '1;
                frm_d.cnt  = '0;
                cap_d      = cfg_wr_t'({frm_q.body[BODY_W-2:0], sdat});
                tog_d      = ~tog_q;
            end
        end
    end

    // Framing state: cleared by reset, select high or enable low.
    always_ff @(posedge sclk or posedge clr) begin
        if (clr) frm_q <= FRM_RST;
        else     frm_q <= frm_d;
    end

    // Capture and toggle survive a select rise so the handshake never reverts.
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
            tog_q <= 1'b0;
        end else begin
            cap_q <= cap_d;
            tog_q <= tog_d;
        end
    end

    assign cap = cap_q;
    assign tog = tog_q;

    // R4: the last body bit always hands the frame over, so the next bit starts a new search
    p_handoff_r4: assert property (@(posedge sclk) disable iff (clr)
        (frm_q.lock && frm_q.cnt == CNT_W'(BODY_W-1)) |=> (tog_q != $past(tog_q)));
endmodule

// File: rtl/cfg_sync_event.sv
`timescale 1ns/1ps
module cfg_sync_event #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic evt
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.chain = {sync_q.chain[CHAIN_W-2:0], tog_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    generate
        if (SYNC_STAGES >= 2) begin : g_edge
            assign evt = sync_q.chain[CHAIN_W-1] ^ sync_q.chain[CHAIN_W-2];
        end else begin : g_edge_min
            assign evt = sync_q.chain[1] ^ sync_q.chain[0];
        end
    endgenerate
endmodule

// File: rtl/cfg_reg_bank.sv
`timescale 1ns/1ps
module cfg_reg_bank
    import cfg_rx_pkg::*;
#(
    parameter logic [NREG-1:0] IMPL_MASK = 16'h7F0F
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [ADR_W-1:0]      waddr,
    input  logic [DAT_W-1:0]      wdata,
    output logic [NREG*DAT_W-1:0] regs_o
);
    typedef struct packed {
        logic [NREG-1:0][DAT_W-1:0] slot;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we && IMPL_MASK[waddr]) bank_d.slot[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) bank_q.slot[i] <= cfg_default(ADR_W'(i));
        end else begin
            bank_q <= bank_d;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        if (IMPL_MASK[g]) begin : g_impl
            assign regs_o[g*DAT_W +: DAT_W] = bank_q.slot[g];
        end else begin : g_rsvd
            assign regs_o[g*DAT_W +: DAT_W] = cfg_default(ADR_W'(g));
        end
    end

    // R9: without a write request the bank holds its contents
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(bank_q));
endmodule

// File: rtl/cfg_serial_rx.sv
`timescale 1ns/1ps
module cfg_serial_rx
    import cfg_rx_pkg::*;
#(
    parameter logic [NREG-1:0] IMPL_MASK   = 16'h7F0F,
    parameter int              SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ext_en,
    input  logic                  ser_clk,
    input  logic                  ser_dat,
    input  logic                  ser_sel_n,
    output logic                  wr_stb,
    output logic [ADR_W-1:0]      wr_addr,
    output logic [DAT_W-1:0]      wr_data,
    output logic [NREG*DAT_W-1:0] cfg_regs
);
    typedef struct packed {
        logic             stb;
        logic [ADR_W-1:0] addr;
        logic [DAT_W-1:0] data;
    } wr_out_t;

    logic    ser_clr;
    cfg_wr_t cap;
    logic    tog;
    logic    evt;
    logic    hit;
    wr_out_t out_d, out_q;

    assign ser_clr = ~rst_n | ser_sel_n | ~ext_en;

    cfg_shift_rx u_shift (
        .sclk  (ser_clk),
        .sdat  (ser_dat),
        .clr   (ser_clr),
        .rst_n (rst_n),
        .cap   (cap),
        .tog   (tog)
    );

    cfg_sync_event #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .tog_in (tog),
        .evt    (evt)
    );

    assign hit = evt & IMPL_MASK[cap.addr];

    always_comb begin
        out_d     = out_q;
        out_d.stb = hit;
        if (hit) begin
            out_d.addr = cap.addr;
            out_d.data = cap.data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    cfg_reg_bank #(.IMPL_MASK(IMPL_MASK)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (hit),
        .waddr  (cap.addr),
        .wdata  (cap.data),
        .regs_o (cfg_regs)
    );

    assign wr_stb  = out_q.stb;
    assign wr_addr = out_q.addr;
    assign wr_data = out_q.data;

    // R3: the strobe never lasts longer than one cycle
    p_stb_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
    // R8: a strobe only ever names an implemented address
    p_stb_impl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> IMPL_MASK[wr_addr]);
    // R2: in the strobe cycle the bank already holds the written value
    p_bank_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (cfg_regs[wr_addr*DAT_W +: DAT_W] == wr_data));
    // R9: the bank outputs move only together with a strobe
    p_change_needs_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_regs) |-> wr_stb);
endmodule

// File: tb/cfg_serial_rx_tb.sv
`timescale 1ns/1ps
module cfg_serial_rx_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ext_en = 1'b0;
    logic         ser_clk = 1'b0;
    logic         ser_dat = 1'b0;
    logic         ser_sel_n = 1'b1;
    logic         wr_stb;
    logic [3:0]   wr_addr;
    logic [15:0]  wr_data;
    logic [255:0] cfg_regs;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    string cur_req = "R1";
    bit    done = 0;

    // behavioural model
    bit          hunt_q[$];
    bit          body_q[$];
    bit          locked = 0;
    int          exp_cyc[$];
    int          exp_val[$];
    logic [15:0] mbank [16];
    localparam logic [15:0] IMPL = 16'h7F0F;

    cfg_serial_rx u_dut (
        .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .ser_sel_n(ser_sel_n), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .cfg_regs(cfg_regs)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] dflt(input int a);
        return {4'hA, 4'(a), 8'h5A};
    endfunction

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        hunt_q.delete();
        body_q.delete();
        locked = 0;
    endtask

    // model of one accepted serial bit (R2, R4, R5)
    task automatic model_bit(input bit b);
        int v;
        if (!locked) begin
            hunt_q.push_back(b);
            if (hunt_q.size() > 12) void'(hunt_q.pop_front());
            if (hunt_q.size() == 12) begin
                v = 0;
                foreach (hunt_q[i]) v = (v << 1) | int'(hunt_q[i]);
                if (v == 1) begin
                    locked = 1;
                    body_q.delete();
                end
            end
        end else begin
            body_q.push_back(b);
            if (body_q.size() == 20) begin
                v = 0;
                foreach (body_q[i]) v = (v << 1) | int'(body_q[i]);
                // R3: strobe due on the third clk edge after the last bit
                if (IMPL[v >> 16]) begin
                    exp_cyc.push_back(cyc + 3);
                    exp_val.push_back(v);
                end
                locked = 0;
                hunt_q.delete();
            end
        end
    endtask

    task automatic send_bit(input bit b);
        @(posedge clk); #1;
        ser_clk = 1'b0;
        ser_dat = b;
        @(posedge clk);
        @(posedge clk); #2;
        ser_clk = 1'b1;
        if (!ser_sel_n && ext_en) model_bit(b);
        @(posedge clk);
    endtask

    task automatic send_frame(input logic [11:0] hdr, input logic [3:0] a, input logic [15:0] d);
        logic [31:0] w;
        w = {hdr, a, d};
        for (int i = 31; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic sel_pulse();
        @(posedge clk); #1;
        ser_sel_n = 1'b1;
        model_clear();
        repeat (4) @(posedge clk);
        #1 ser_sel_n = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(posedge clk);
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_stb;
            exp_stb = (exp_cyc.size() > 0) && (exp_cyc[0] == cyc);
            check(wr_stb == exp_stb, "wr_stb", 32'(wr_stb), 32'(exp_stb));
            if (exp_cyc.size() > 0 && exp_cyc[0] < cyc) begin
                check(0, "missed strobe", 32'(cyc), 32'(exp_cyc[0]));
                void'(exp_cyc.pop_front());
                void'(exp_val.pop_front());
            end
            if (exp_stb) begin
                check(wr_addr == 4'(exp_val[0] >> 16), "wr_addr", 32'(wr_addr), 32'(exp_val[0] >> 16));
                check(wr_data == 16'(exp_val[0]), "wr_data", 32'(wr_data), 32'(16'(exp_val[0])));
                mbank[exp_val[0] >> 16] = 16'(exp_val[0]);
                void'(exp_cyc.pop_front());
                void'(exp_val.pop_front());
            end
            for (int a = 0; a < 16; a++) begin
                if (cfg_regs[a*16 +: 16] !== mbank[a])
                    check(0, $sformatf("reg %0d", a), 32'(cfg_regs[a*16 +: 16]), 32'(mbank[a]));
            end
            n_chk++;
        end
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int a = 0; a < 16; a++) mbank[a] = dflt(a);
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        settle();
        cur_req = "R1";
        check(wr_stb == 1'b0, "reset strobe", 32'(wr_stb), 0);
        check(cfg_regs[3*16 +: 16] == 16'hA35A, "reset default", 32'(cfg_regs[3*16 +: 16]), 32'hA35A);

        #1 ext_en = 1'b1;
        ser_sel_n = 1'b0;

        cur_req = "R2";
        send_frame(12'h001, 4'h0, 16'h1234);
        cur_req = "R3";
        send_frame(12'h001, 4'h9, 16'hBEEF);
        settle();

        cur_req = "R4";
        send_frame(12'h001, 4'h3, 16'h0001);
        send_frame(12'h001, 4'h8, 16'hFFFF);
        send_frame(12'h001, 4'hE, 16'h8000);
        send_frame(12'h001, 4'h3, 16'h5AA5);
        settle();

        cur_req = "R8";
        send_frame(12'h001, 4'h5, 16'hDEAD);
        send_frame(12'h001, 4'hF, 16'hCAFE);
        send_frame(12'h001, 4'h2, 16'h0F0F);
        settle();

        cur_req = "R5";
        send_frame(12'h003, 4'h1, 16'h0000);
        send_frame(12'h801, 4'h1, 16'h7777);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        send_frame(12'h001, 4'h1, 16'h4321);
        settle();

        cur_req = "R6";
        for (int i = 0; i < 20; i++) send_bit(i == 11);
        sel_pulse();
        for (int i = 0; i < 6; i++) send_bit(1'b0);
        sel_pulse();
        send_frame(12'h001, 4'hA, 16'h00C3);
        settle();

        cur_req = "R7";
        #1 ext_en = 1'b0;
        model_clear();
        send_frame(12'h001, 4'hB, 16'h9999);
        settle();
        #1 ext_en = 1'b1;
        cur_req = "R9";
        send_frame(12'h001, 4'hB, 16'h3C3C);
        repeat (20) @(posedge clk);

        check(exp_cyc.size() == 0, "pending writes", 32'(exp_cyc.size()), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule